// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Priority Stack

This controller collects level-sensitive hardware interrupt lines and a bank of software-raised requests. Each source has its own 4-bit priority. The controller compares the strongest pending request against a current-priority register and asserts a request toward one processor only when that request outranks the running level.

The processor acknowledges an interrupt by reading the vector register. The read returns the source number. At the same time the controller saves the current level on an internal stack and adopts the priority of the granted source. A write to the end-of-interrupt register restores the saved level. The stack has one slot for each priority level.

A second write-only port reaches only the software-request register. Through it another processor can post work to this one. A level may be lowered below the priority of the running handler. This is legal, but it can fill the stack, and once the stack is full, acknowledges are refused.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source i has a PRIO_W-bit priority held at word address 4 + i/(DATA_W/PRIO_W), in bits [PRIO_W*(i%(DATA_W/PRIO_W)) +: PRIO_W]. The field can be read back as written.
- R2: A write to word address 3 sets the pending request of software source j when bit j is 1. A write of 0 to bit j has no effect.
- R3: On a read of address 3, bit N_SW+j returns 1 while software request j is pending, and bits [N_SW-1:0] return 0. Writing 1 to bit N_SW+j clears request j. If the same write both sets and clears a request, the request ends up set.
- R4: A write on the remote port to address 3 acts the same way as a local write to address 3. A remote write to any other address is ignored.
- R5: irq_req is 1 exactly when some pending source has a priority strictly greater than the current priority. A source with priority 0 never requests.
- R6: Software sources are numbered 0..N_SW-1 and hardware line k is number N_SW+k. Among pending sources of equal top priority, the lowest number wins. irq_vec and irq_prio show the winner.
- R7: A read of address 0 while irq_req is 1 and the stack is not full returns bit DATA_W-1 set, with the winner's number in the low bits. The same read pushes the current priority and loads the winner's priority as the current priority. In any other case the read returns 0 and changes nothing.
- R8: A write to address 1 pops the stack into the current priority. When the stack is empty, the write is ignored.
- R9: The stack holds 2**PRIO_W entries. When the stack is full, an acknowledge is refused as described in R7, while irq_req still follows R5.
- R10: The current priority can be read and written at address 2, in bits [PRIO_W-1:0].
- R11: After reset, the current priority is 0, all priorities are 0, no software request is pending and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | N_HW | Level-sensitive hardware interrupt lines |
| bus_sel | input | 1 | Local bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Local word address |
| bus_wdata | input | DATA_W | Local write data |
| bus_rdata | output | DATA_W | Local read data, valid in the cycle of bus_sel |
| rmt_we | input | 1 | Remote processor write strobe |
| rmt_addr | input | ADDR_W | Remote word address |
| rmt_wdata | input | DATA_W | Remote write data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Number of the winning source |
| irq_prio | output | PRIO_W | Priority of the winning source |

## Verification
The bench builds the block with four software sources and four hardware lines, so all eight priority fields fit in one register. This makes it possible to sweep every source through all sixteen priority levels, to try every pair of sources for tie-breaking, and to sweep the current level against a fixed request. With PRIO_W at 4 the stack has only sixteen slots. A chain of fifteen nested acknowledges, followed by a lowered level and one more acknowledge, fills the stack completely, so both the refused acknowledge and the ignored pop on an empty stack can be reached.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    // Word addresses of the register map
    localparam int unsigned ADR_VEC       = 0;
    localparam int unsigned ADR_EOI       = 1;
    localparam int unsigned ADR_CUR       = 2;
    localparam int unsigned ADR_SWI       = 3;
    localparam int unsigned ADR_PRIO_BASE = 4;
endpackage

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
    parameter int N  = 32,
    parameter int PW = 4,
    parameter int IW = 5
) (
    input  logic [N-1:0]         pend,
    input  logic [N-1:0][PW-1:0] prio,
    output logic [PW-1:0]        win_prio,
    output logic [IW-1:0]        win_idx
);
    // Strict comparison keeps the lowest index on ties; priority 0 never wins.
    always_comb begin
        win_prio = '0;
        win_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (prio[i] > win_prio)) begin
                win_prio = prio[i];
                win_idx  = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_lifo.sv
module prio_irq_lifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  push_val,
    output logic [W-1:0]  top_val,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } lifo_t;

    lifo_t lf_d, lf_q;
    logic [AW-1:0] top_idx;

    always_comb begin
        lf_d    = lf_q;
        full    = (lf_q.cnt == CW'(DEPTH));
        empty   = (lf_q.cnt == '0);
        top_idx = AW'(lf_q.cnt - CW'(1));
        top_val = empty ? '0 : lf_q.mem[top_idx];
        level   = lf_q.cnt;
        if (push && !full) begin
            lf_d.mem[AW'(lf_q.cnt)] = push_val;
            lf_d.cnt                = lf_q.cnt + CW'(1);
        end else if (pop && !empty) begin
            lf_d.cnt = lf_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf_q <= '0;
        else        lf_q <= lf_d;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_HW   = 24,
    parameter int N_SW   = 8,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int N_SRC  = N_SW + N_HW,
    parameter int VEC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HW-1:0]   hw_irq,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rmt_we,
    input  logic [ADDR_W-1:0] rmt_addr,
    input  logic [DATA_W-1:0] rmt_wdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [PRIO_W-1:0] irq_prio
);
    import prio_irq_pkg::*;

    localparam int LEVELS = 1 << PRIO_W;
    localparam int FPR    = DATA_W / PRIO_W;   // priority fields per register
    localparam int LVL_W  = $clog2(LEVELS + 1);

    typedef struct packed {
        logic [PRIO_W-1:0]             cur;
        logic [N_SW-1:0]               swp;
        logic [N_SRC-1:0][PRIO_W-1:0]  prio;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [N_SRC-1:0]  pend;
    logic [PRIO_W-1:0] win_prio;
    logic [VEC_W-1:0]  win_idx;
    logic              stk_push, stk_pop;
    logic [PRIO_W-1:0] stk_top;
    logic [LVL_W-1:0]  stk_level;
    logic              stk_full, stk_empty;
    logic              rd_en, wr_en, ack_ok;
    logic [N_SW-1:0]   set_v, clr_v;

    assign pend = {hw_irq, st_q.swp};

    prio_irq_arb #(.N(N_SRC), .PW(PRIO_W), .IW(VEC_W)) u_arb (
        .pend     (pend),
        .prio     (st_q.prio),
        .win_prio (win_prio),
        .win_idx  (win_idx)
    );

    prio_irq_lifo #(.DEPTH(LEVELS), .W(PRIO_W), .CW(LVL_W)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (st_q.cur),
        .top_val  (stk_top),
        .level    (stk_level),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    assign irq_req  = (win_prio > st_q.cur);
    assign irq_vec  = win_idx;
    assign irq_prio = win_prio;

    always_comb begin
        st_d      = st_q;
        bus_rdata = '0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        rd_en     = bus_sel && !bus_we;
        wr_en     = bus_sel &&  bus_we;
        ack_ok    = irq_req && !stk_full;
        set_v     = '0;
        clr_v     = '0;

        // Software request bank: local and remote writes merge, sets win.
        if (wr_en && bus_addr == ADDR_W'(ADR_SWI)) begin
            set_v = set_v | bus_wdata[N_SW-1:0];
            clr_v = clr_v | bus_wdata[2*N_SW-1:N_SW];
        end
        if (rmt_we && rmt_addr == ADDR_W'(ADR_SWI)) begin
            set_v = set_v | rmt_wdata[N_SW-1:0];
            clr_v = clr_v | rmt_wdata[2*N_SW-1:N_SW];
        end
        st_d.swp = (st_q.swp & ~clr_v) | set_v;

        if (bus_addr == ADDR_W'(ADR_VEC)) begin
            if (ack_ok) begin
                bus_rdata[DATA_W-1]  = 1'b1;
                bus_rdata[VEC_W-1:0] = win_idx;
                if (rd_en) begin
                    stk_push = 1'b1;
                    st_d.cur = win_prio;
                end
            end
        end else if (bus_addr == ADDR_W'(ADR_EOI)) begin
            if (wr_en && !stk_empty) begin
                stk_pop  = 1'b1;
                st_d.cur = stk_top;
            end
        end else if (bus_addr == ADDR_W'(ADR_CUR)) begin
            bus_rdata[PRIO_W-1:0] = st_q.cur;
            if (wr_en) st_d.cur = bus_wdata[PRIO_W-1:0];
        end else if (bus_addr == ADDR_W'(ADR_SWI)) begin
            bus_rdata[2*N_SW-1:N_SW] = st_q.swp;
        end

        for (int i = 0; i < N_SRC; i++) begin
            if (bus_addr == ADDR_W'(ADR_PRIO_BASE + i / FPR)) begin
                bus_rdata[PRIO_W*(i%FPR) +: PRIO_W] = st_q.prio[i];
                if (wr_en) st_d.prio[i] = bus_wdata[PRIO_W*(i%FPR) +: PRIO_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N_SW   = 8,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rmt_we,
    input logic [ADDR_W-1:0] rmt_addr,
    input logic [DATA_W-1:0] rmt_wdata,
    input logic              irq_req,
    input logic [PRIO_W-1:0] irq_prio,
    input logic [PRIO_W-1:0] cur,
    input logic [PRIO_W-1:0] stk_top,
    input logic [LVL_W-1:0]  stk_level,
    input logic              stk_full,
    input logic [N_SW-1:0]   sw_pend
);
    import prio_irq_pkg::*;

    localparam int LEVELS = 1 << PRIO_W;

    logic ack_fire, eoi_wr, rmt_swi;
    assign ack_fire = bus_sel && !bus_we && bus_addr == ADDR_W'(ADR_VEC) && irq_req && !stk_full;
    assign eoi_wr   = bus_sel &&  bus_we && bus_addr == ADDR_W'(ADR_EOI);
    assign rmt_swi  = rmt_we && rmt_addr == ADDR_W'(ADR_SWI);

    // R7: an acknowledge adopts the winner's priority
    a_r7_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> cur == $past(irq_prio));

    // R9: an accepted acknowledge grows the stack by one
    a_r9_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> stk_level == $past(stk_level) + LVL_W'(1));

    // R9: the stack never exceeds one slot per level
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        stk_level <= LVL_W'(LEVELS));

    // R8: end-of-interrupt restores the saved level
    a_r8_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_level != '0) |=> cur == $past(stk_top));

    // R8: end-of-interrupt on an empty stack changes nothing
    a_r8_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_level == '0) |=> ($stable(cur) && stk_level == '0));

    // R4: remote set bits take effect on the next cycle
    a_r4_remote_set: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_swi |=> (sw_pend & $past(rmt_wdata[N_SW-1:0])) == $past(rmt_wdata[N_SW-1:0]));

    // R5: a request always carries a nonzero priority above the current one
    a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio != '0 && irq_prio > cur));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .N_SW(N_SW), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .rmt_we    (rmt_we),
    .rmt_addr  (rmt_addr),
    .rmt_wdata (rmt_wdata),
    .irq_req   (irq_req),
    .irq_prio  (irq_prio),
    .cur       (st_q.cur),
    .stk_top   (stk_top),
    .stk_level (stk_level),
    .stk_full  (stk_full),
    .sw_pend   (st_q.swp)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int NHW = 4;
    localparam int NSW = 4;
    localparam int NS  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hw_irq = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rmt_we = 1'b0;
    logic [3:0]  rmt_addr = '0;
    logic [31:0] rmt_wdata = '0;
    logic        irq_req;
    logic [2:0]  irq_vec;
    logic [3:0]  irq_prio;

    int checks = 0;
    int failures = 0;
    int pr [NS];

    always #4 clk = ~clk;

    prio_irq_ctrl #(.N_HW(NHW), .N_SW(NSW), .PRIO_W(4), .DATA_W(32), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rmt_we(rmt_we), .rmt_addr(rmt_addr), .rmt_wdata(rmt_wdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_prio(irq_prio)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rwr(int a, logic [31:0] d);
        @(negedge clk);
        rmt_we = 1'b1; rmt_addr = 4'(a); rmt_wdata = d;
        @(negedge clk);
        rmt_we = 1'b0;
    endtask

    function automatic logic [31:0] pack_prio();
        logic [31:0] v = '0;
        for (int i = 0; i < NS; i++) v[4*i +: 4] = 4'(pr[i]);
        return v;
    endfunction

    // Program priorities and pending mask (bits 0..3 software, 4..7 hardware)
    task automatic apply(int mask);
        logic [31:0] sw;
        hw_irq = 4'(mask >> 4);
        wr(4, pack_prio());
        sw = 32'(((~mask & 15) << 4) | (mask & 15));
        wr(3, sw);
    endtask

    task automatic expect_arb(string req, int mask, int cur);
        int bp = 0, bi = 0;
        for (int i = 0; i < NS; i++)
            if (((mask >> i) & 1) != 0 && pr[i] > bp) begin bp = pr[i]; bi = i; end
        check(req, 32'(irq_req), 32'(bp > cur));
        if (bp > cur) begin
            check(req, 32'(irq_vec), 32'(bi));
            check(req, 32'(irq_prio), 32'(bp));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NS; i++) pr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        check("R11 irq_req", 32'(irq_req), 0);
        rd(2, d); check("R11 cur", d, 0);
        rd(3, d); check("R11 swi", d, 0);
        rd(4, d); check("R11 prio", d, 0);
        // R7 acknowledge with nothing pending
        rd(0, d); check("R7 idle ack", d, 0);
        rd(2, d); check("R7 idle cur", d, 0);

        // R1 R5 R6: each source alone through every priority
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 16; p++) begin
                for (int i = 0; i < NS; i++) pr[i] = 0;
                pr[s] = p;
                apply(1 << s);
                rd(4, d); check("R1 readback", d, pack_prio());
                expect_arb("R5 single", 1 << s, 0);
            end
        end

        // R5 R10: strict comparison against every current level
        for (int i = 0; i < NS; i++) pr[i] = 0;
        pr[5] = 9;
        apply(1 << 5);
        for (int c = 0; c < 16; c++) begin
            wr(2, 32'(c));
            rd(2, d); check("R10 cur rw", d, 32'(c));
            expect_arb("R5 strict", 1 << 5, c);
        end
        wr(2, 0);

        // R6: every pair, equal and then higher priority
        for (int a = 0; a < NS; a++) begin
            for (int b = a + 1; b < NS; b++) begin
                for (int i = 0; i < NS; i++) pr[i] = 0;
                pr[a] = 7; pr[b] = 7;
                apply((1 << a) | (1 << b));
                check("R6 tie", 32'(irq_vec), 32'(a));
                pr[b] = 8;
                apply((1 << a) | (1 << b));
                check("R6 higher", 32'(irq_vec), 32'(b));
            end
        end

        // R5 R6: mixed patterns
        for (int k = 0; k < 64; k++) begin
            for (int i = 0; i < NS; i++) pr[i] = (k * 7 + i * 5) % 16;
            apply((k * 37 + 11) % 256);
            expect_arb("R6 mixed", (k * 37 + 11) % 256, 0);
        end

        // R2 R3: set, write zero, set and clear together, clear
        hw_irq = '0;
        for (int i = 0; i < NS; i++) pr[i] = 0;
        wr(4, 0);
        wr(3, 32'hF0);
        rd(3, d); check("R3 cleared", d, 0);
        wr(3, 32'h11);
        rd(3, d); check("R3 set wins", d, 32'h10);
        wr(3, 32'h0);
        rd(3, d); check("R2 zero no effect", d, 32'h10);
        wr(3, 32'h2);
        rd(3, d); check("R2 set", d, 32'h30);
        wr(3, 32'h10);
        rd(3, d); check("R3 clear", d, 32'h20);
        wr(3, 32'h20);
        rd(3, d); check("R3 clear all", d, 0);

        // R4: remote port
        rwr(3, 32'h4);
        rd(3, d); check("R4 remote set", d, 32'h40);
        rwr(2, 32'h8);
        rd(3, d); check("R4 other addr ignored", d, 32'h40);
        rd(2, d); check("R4 cur untouched", d, 0);
        rwr(3, 32'h40);
        rd(3, d); check("R4 remote clear", d, 0);

        // R7 R9: fifteen nested acknowledges on source 0
        for (int p = 1; p < 16; p++) begin
            wr(4, 32'(p));
            wr(3, 32'h1);
            rd(0, d); check("R7 ack", d, 32'h8000_0000);
            rd(2, d); check("R7 cur", d, 32'(p));
            wr(3, 32'h10);
        end
        // Lower the level and fill the last slot
        wr(2, 0);
        wr(4, 32'h1);
        wr(3, 32'h1);
        rd(0, d); check("R9 last slot", d, 32'h8000_0000);
        rd(2, d); check("R9 last cur", d, 1);
        wr(2, 0);
        check("R9 req when full", 32'(irq_req), 1);
        rd(0, d); check("R9 full refuse", d, 0);
        rd(2, d); check("R9 full cur", d, 0);
        wr(3, 32'h10);

        // R8: unwind
        for (int k = 0; k < 16; k++) begin
            wr(1, 0);
            rd(2, d);
            check("R8 pop", d, (k == 0) ? 32'd0 : 32'(15 - k));
        end
        wr(2, 5);
        wr(1, 0);
        rd(2, d); check("R8 empty pop ignored", d, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule